// File: doc/BRIEF.md
# Nine-bit command frame serializer

This block sends one display-panel command per request over a write-only serial link. A command is an 8-bit opcode followed by zero, one or two 8-bit parameters. On the wire, each of these becomes a 9-bit word: one flag bit that marks the word as command or data, then the eight payload bits. The words are placed back to back from the first bit of the frame. Zero bits then fill the frame out to a whole number of bytes, so a frame is 2, 3 or 4 bytes long.

The requester presents the opcode, both parameter bytes and a 2-bit parameter count together with a start strobe. The request is taken in a cycle where ready is high. Ready then stays low until the single-cycle done pulse. The serial clock idles high. The receiver samples on the rising edge and data moves only after falling edges. The serial clock runs at the system clock divided by an even parameter. Chip select is held low across the whole frame, and a count of three is rejected without touching the link.

Top module: `cmd9_serializer`

## Requirements
- R1: The first word on the wire is the opcode word: a flag bit of 0 followed by opcode bits 7 down to 0.
- R2: Each parameter word carries a flag bit of 1 followed by its byte MSB first. Parameter 0 is sent before parameter 1, and a parameter beyond the count is not sent.
- R3: A frame with count N (0, 1 or 2) has exactly 8*(N+2) rising serial clock edges while chip select is low.
- R4: After the last word, the frame carries 7, 6 or 5 zero bits for counts 0, 1 and 2.
- R5: The serial clock and chip select are high whenever no frame is in progress.
- R6: The data line changes only while the serial clock is low or on its falling edge. It never changes while the clock stays high, so it is stable at every rising edge.
- R7: Chip select falls at least half a serial period before the first falling clock edge and rises at least half a period after the last rising edge. The serial clock is high whenever chip select is high.
- R8: Between consecutive frames, chip select stays high for at least CLK_DIV system clock cycles.
- R9: A request with count 3 produces a done pulse and leaves chip select high with no serial clock edges.
- R10: Ready is high only when idle. It is low from the accepted start until the single-cycle done pulse. Start and the inputs are ignored while busy.
- R11: Within a frame, the serial clock period is exactly CLK_DIV system clock cycles.
- R12: After reset, ready is 1, done is 0, chip select is 1, the serial clock is 1 and the data line is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when ready_o is high |
| ready_o | output | 1 | Idle and able to take a request |
| opcode_i | input | 8 | Command byte |
| param0_i | input | 8 | First parameter byte |
| param1_i | input | 8 | Second parameter byte |
| param_cnt_i | input | 2 | Number of parameters, 0 to 2; 3 is rejected |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Chip select, active low |
| done_o | output | 1 | One-cycle pulse at the end of a request |

## Verification
The assertions assume that start_i and the request fields are steady at each rising system clock edge and that the reset is released synchronously. The bench meets this by changing every input only on the falling system clock edge. The protocol properties also assume that the requester does not rely on a start that arrives while ready is low. The bench drives such starts on purpose, with different data, and checks that the frame in progress is unchanged. Parameter bytes above the count carry nonzero patterns so that any leak into the frame would show in the received bits.

// File: rtl/cmd9_pkg.sv
package cmd9_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = BYTE_W + 1;
  localparam int unsigned MAX_PRM = 2;
  localparam int unsigned N_WORDS = MAX_PRM + 1;
  localparam int unsigned FRAME_W = (MAX_PRM + 2) * BYTE_W;
  localparam int unsigned FILL_W  = FRAME_W - N_WORDS * WORD_W;
  localparam int unsigned BCNT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP,
    ST_DONE
  } ser_state_e;
endpackage

// File: rtl/cmd9_frame_pack.sv
module cmd9_frame_pack
  import cmd9_pkg::*;
(
  input  logic [BYTE_W-1:0]  opcode_i,
  input  logic [BYTE_W-1:0]  param0_i,
  input  logic [BYTE_W-1:0]  param1_i,
  input  logic [1:0]         param_cnt_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [BCNT_W-1:0]  nbits_o,
  output logic               bad_cnt_o
);
  logic [BYTE_W-1:0] payload [N_WORDS];
  logic [N_WORDS*WORD_W-1:0] words;

  assign payload[0] = opcode_i;
  assign payload[1] = param0_i;
  assign payload[2] = param1_i;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    localparam int unsigned HI = (N_WORDS - k) * WORD_W - 1;
    logic keep;
    assign keep = (k == 0) || (int'(param_cnt_i) >= k);
    // flag: 0 for the opcode word, 1 for parameter words
    assign words[HI -: WORD_W] = keep ? {(k != 0) ? 1'b1 : 1'b0, payload[k]}
                                      : '0;
  end

  assign frame_o   = {words, {FILL_W{1'b0}}};
  assign bad_cnt_o = (param_cnt_i == 2'd3);
  assign nbits_o   = BCNT_W'((int'(param_cnt_i) + 2) * BYTE_W);
endmodule

// File: rtl/cmd9_half_tick.sv
module cmd9_half_tick #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  a_r11_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r11_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/cmd9_shift_ctrl.sv
module cmd9_shift_ctrl
  import cmd9_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [BCNT_W-1:0]  nbits_i,
  input  logic               bad_cnt_i,
  input  logic               tick_i,
  output logic               tick_en_o,
  output logic               ready_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               cs_n_o
);
  ser_state_e state_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BCNT_W-1:0]  left_q;
  logic               gap_q;
  logic               sclk_q, mosi_q, cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      gap_q   <= 1'b0;
      sclk_q  <= 1'b1;
      mosi_q  <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (bad_cnt_i) begin
            state_q <= ST_DONE;
          end else begin
            sh_q    <= frame_i;
            left_q  <= nbits_i;
            cs_n_q  <= 1'b0;
            state_q <= ST_LEAD;
          end
        end
        ST_LEAD: if (tick_i) begin
          sclk_q  <= 1'b0;
          mosi_q  <= sh_q[FRAME_W-1];
          sh_q    <= sh_q << 1;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick_i) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
            mosi_q <= sh_q[FRAME_W-1];
            sh_q   <= sh_q << 1;
          end else begin
            sclk_q <= 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == BCNT_W'(1)) state_q <= ST_TAIL;
          end
        end
        ST_TAIL: if (tick_i) begin
          cs_n_q  <= 1'b1;
          mosi_q  <= 1'b0;
          gap_q   <= 1'b0;
          state_q <= ST_GAP;
        end
        ST_GAP: if (tick_i) begin
          if (gap_q) state_q <= ST_DONE;
          else       gap_q   <= 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tick_en_o = (state_q == ST_LEAD) || (state_q == ST_SHIFT) ||
                     (state_q == ST_TAIL) || (state_q == ST_GAP);
  assign ready_o   = (state_q == ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;
  assign cs_n_o    = cs_n_q;

  // R7: no clock activity outside chip select
  a_r7_sclk_high_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> sclk_o);
  // R6: data holds while the clock stays high
  a_r6_mosi_stable_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  // R10: done lasts one cycle and never overlaps ready
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_ready_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && done_o));
  a_r10_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_o) |=> !ready_o);
  // R9: a count of three is rejected without selecting the panel
  a_r9_reject_bad_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && bad_cnt_i) |=> (done_o && cs_n_o));
  // R3: the remaining-bit counter never exceeds a full frame
  a_r3_left_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= BCNT_W'(FRAME_W));
  // R5: clock rises only while selected
  a_r5_rise_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> !cs_n_o);
endmodule

// File: rtl/cmd9_serializer.sv
module cmd9_serializer
  import cmd9_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              ready_o,
  input  logic [BYTE_W-1:0] opcode_i,
  input  logic [BYTE_W-1:0] param0_i,
  input  logic [BYTE_W-1:0] param1_i,
  input  logic [1:0]        param_cnt_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_n_o,
  output logic              done_o
);
  localparam int unsigned HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

  logic [FRAME_W-1:0] frame;
  logic [BCNT_W-1:0]  nbits;
  logic               bad_cnt;
  logic               tick, tick_en;

  cmd9_frame_pack i_pack (
    .opcode_i    (opcode_i),
    .param0_i    (param0_i),
    .param1_i    (param1_i),
    .param_cnt_i (param_cnt_i),
    .frame_o     (frame),
    .nbits_o     (nbits),
    .bad_cnt_o   (bad_cnt)
  );

  cmd9_half_tick #(.HALF(HALF)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en),
    .tick_o (tick)
  );

  cmd9_shift_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .frame_i   (frame),
    .nbits_i   (nbits),
    .bad_cnt_i (bad_cnt),
    .tick_i    (tick),
    .tick_en_o (tick_en),
    .ready_o   (ready_o),
    .done_o    (done_o),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .cs_n_o    (cs_n_o)
  );
endmodule

// File: tb/test_cmd9_serializer.sv
`timescale 1ns/1ps
module test_cmd9_serializer;
  localparam int unsigned CLK_DIV = 4;
  localparam realtime TCLK = 20.0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [7:0] op = '0, p0 = '0, p1 = '0;
  logic [1:0] cnt = '0;
  logic ready, sclk, mosi, cs_n, done;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(TCLK/2) clk = ~clk;

  cmd9_serializer #(.CLK_DIV(CLK_DIV)) i_cmd9_serializer (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .ready_o(ready),
    .opcode_i(op), .param0_i(p0), .param1_i(p1), .param_cnt_i(cnt),
    .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n), .done_o(done)
  );

  // receiver model
  logic [31:0] rx = '0;
  int rx_cnt = 0;
  int cs_falls = 0;
  realtime last_rise = 0, per_min = 1e9, per_max = 0;
  realtime cs_rise_t = 0, gap_min = 1e9;
  bit seen_frame = 1'b0;
  int unstable = 0;
  logic prev_sclk = 1'b1, prev_mosi = 1'b0;
  int lead_bad = 0;

  always @(negedge cs_n) begin
    cs_falls++;
    rx = '0; rx_cnt = 0;
    per_min = 1e9; per_max = 0; last_rise = 0;
    if (seen_frame && ($realtime - cs_rise_t) < gap_min) gap_min = $realtime - cs_rise_t;
  end
  always @(posedge cs_n) begin
    cs_rise_t = $realtime;
    seen_frame = 1'b1;
  end
  always @(posedge sclk) if (!cs_n) begin
    rx = {rx[30:0], mosi};
    if (rx_cnt > 0) begin
      if ($realtime - last_rise < per_min) per_min = $realtime - last_rise;
      if ($realtime - last_rise > per_max) per_max = $realtime - last_rise;
    end
    last_rise = $realtime;
    rx_cnt++;
  end
  always @(negedge clk) begin
    if (rst_ni && sclk && prev_sclk && (mosi !== prev_mosi)) unstable++;
    if (rst_ni && cs_n && !sclk) lead_bad++;
    prev_sclk = sclk; prev_mosi = mosi;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // sends a request; optionally pokes start with other data while busy
  task automatic send(input logic [7:0] o, input logic [7:0] a, input logic [7:0] b,
                      input logic [1:0] n, input bit poke, output int cyc);
    bit ready_bad;
    ready_bad = 1'b0;
    cyc = 0;
    while (!ready) @(negedge clk);
    op = o; p0 = a; p1 = b; cnt = n;
    pulse_start();
    if (poke) begin
      op = ~o; p0 = ~a; p1 = ~b; cnt = 2'd2; start = 1'b1;
    end
    while (!done && cyc < 2000) begin
      if (ready) ready_bad = 1'b1;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    check(!ready_bad, "R10", "ready low while busy", 32'(ready_bad), 0);
    check(done && !ready, "R10", "done pulse seen", 32'(done), 1);
    @(negedge clk);
    check(!done && ready, "R10", "done single cycle", 32'(done), 0);
  endtask

  function automatic logic [31:0] expected(input logic [7:0] o, input logic [7:0] a,
                                           input logic [7:0] b, input logic [1:0] n);
    case (n)
      2'd0: return {16'h0, 1'b0, o, 7'b0};
      2'd1: return {8'h0, 1'b0, o, 1'b1, a, 6'b0};
      default: return {1'b0, o, 1'b1, a, 1'b1, b, 5'b0};
    endcase
  endfunction

  task automatic frame_test(input logic [7:0] o, input logic [7:0] a,
                            input logic [7:0] b, input logic [1:0] n, input bit poke);
    int cyc, nb, falls0, unst0;
    logic [31:0] exp;
    falls0 = cs_falls; unst0 = unstable;
    send(o, a, b, n, poke, cyc);
    nb = (int'(n) + 2) * 8;
    exp = expected(o, a, b, n);
    check(cs_falls == falls0 + 1, "R7", "one chip-select frame", 32'(cs_falls - falls0), 1);
    check(rx_cnt == nb, "R3", "rising edges per frame", 32'(rx_cnt), 32'(nb));
    check(rx == exp, (n == 0) ? "R1" : "R2", "frame bits", rx, exp);
    check((rx & ((32'h1 << (7 - n)) - 1)) == 0, "R4", "zero fill", rx, exp);
    check(per_min == CLK_DIV*TCLK && per_max == CLK_DIV*TCLK, "R11", "sclk period",
          32'(int'(per_max/TCLK)), CLK_DIV);
    check(unstable == unst0, "R6", "mosi stable while sclk high", 32'(unstable - unst0), 0);
    check(cs_n && sclk, "R5", "idle lines high", {cs_n, sclk}, 2'b11);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(ready === 1'b1, "R12", "ready after reset", 32'(ready), 1);
    check(done === 1'b0, "R12", "done after reset", 32'(done), 0);
    check(cs_n === 1'b1 && sclk === 1'b1, "R12", "cs_n/sclk after reset", {cs_n, sclk}, 2'b11);
    check(mosi === 1'b0, "R12", "mosi after reset", 32'(mosi), 0);
  endtask

  task automatic test_illegal();
    int cyc, f0;
    f0 = cs_falls;
    send(8'hA5, 8'h5A, 8'hFF, 2'd3, 1'b0, cyc);
    check(cs_falls == f0, "R9", "no chip select for count 3", 32'(cs_falls - f0), 0);
    check(cyc <= 2, "R9", "quick rejection", 32'(cyc), 2);
  endtask

  task automatic test_gap();
    gap_min = 1e9;
    frame_test(8'h11, 8'h00, 8'h00, 2'd0, 1'b0);
    frame_test(8'hB0, 8'h16, 8'h00, 2'd1, 1'b0);
    check(gap_min >= CLK_DIV*TCLK, "R8", "inter-frame gap", 32'(int'(gap_min/TCLK)), CLK_DIV);
  endtask

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    test_reset();
    frame_test(8'h29, 8'hFF, 8'hF9, 2'd0, 1'b0);      // R1 R4: unused params nonzero
    frame_test(8'hB0, 8'h16, 8'hC3, 2'd1, 1'b0);      // R2 R4
    frame_test(8'hB8, 8'hFF, 8'hF9, 2'd2, 1'b0);      // R2 order
    frame_test(8'h00, 8'h00, 8'h00, 2'd2, 1'b0);      // all-zero payload
    frame_test(8'hFF, 8'h80, 8'h01, 2'd2, 1'b1);      // R10 start ignored while busy
    test_illegal();
    test_gap();
    check(lead_bad == 0, "R7", "sclk low with cs_n high", 32'(lead_bad), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule